// File: doc/BRIEF.md
# Bus Transfer Firewall Gate

This block sits between one IP and a shared on-chip bus and holds every 32-bit data beat until an external policy checker has approved it. Write beats travel from the IP toward the bus, and read-data beats travel from the bus toward the IP. Each direction has its own gating lane. A lane captures one beat, shows its address, direction and size code to the checker, and waits for a completion strobe that carries a pass or fail verdict.

An approved beat first moves through a decision register. It then moves through a bank of synchronization registers that are loaded only by that decision, so the beat's valid, last and byte-strobe qualifiers reach the far side exactly once. A rejected beat is dropped and sets a sticky violation flag. The two lanes share a single checker port through a small arbiter. Each lane has one beat in flight at a time, and the upstream ready signal doubles as the lane's idle indication.

Top module: `xfer_gate`

## Requirements
- R1: After reset `ip_wready` and `bus_rready` are 1, and `bus_wvalid`, `ip_rvalid`, `chk_req` and `viol` are 0.
- R2: When a lane accepts a beat, its upstream ready drops on the next cycle and stays low until the beat is forwarded or dropped. While the checker has not completed, `chk_req` stays high with the captured address, and `chk_size` carries the captured 2-bit size code unchanged. `chk_write` is 1 for the write lane and 0 for the read lane.
- R3: No downstream valid appears on either lane before the checker has returned a pass verdict for that beat.
- R4: When `chk_done` and `chk_pass` are sampled high at clock edge E, the downstream valid of the owning lane goes high at edge E+2, with the captured address, data, last flag and (for writes) byte strobes. It stays high and unchanged until the downstream ready is sampled high.
- R5: Each pass verdict produces exactly one downstream handshake. Valid drops on the edge where the handshake happens, and upstream ready returns on that same edge.
- R6: A fail verdict drops the beat: it never appears downstream, and upstream ready returns on the edge where the verdict is sampled.
- R7: `viol` goes to 1 on the edge where a fail verdict is sampled and stays at 1 until `viol_clr` is sampled high. If a fail verdict and `viol_clr` arrive in the same cycle, the fail verdict wins.
- R8: The lanes are gated independently. When both request the checker in the same cycle with neither already holding it, the write lane is served first. A lane keeps the checker until its completion strobe, and then the other lane's pending beat is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| viol_clr | input | 1 | Clears the sticky violation flag |
| viol | output | 1 | Sticky flag: some beat was rejected |
| ip_wvalid | input | 1 | IP write beat valid |
| ip_wready | output | 1 | Gate ready for a write beat |
| ip_waddr | input | AW | Write beat address |
| ip_wdata | input | DW | Write beat data |
| ip_wstrb | input | DW/8 | Write byte strobes |
| ip_wlast | input | 1 | Write last flag |
| ip_wsize | input | 2 | Write size code |
| bus_wvalid | output | 1 | Forwarded write beat valid |
| bus_wready | input | 1 | Bus accepts write beat |
| bus_waddr | output | AW | Forwarded write address |
| bus_wdata | output | DW | Forwarded write data |
| bus_wstrb | output | DW/8 | Forwarded byte strobes |
| bus_wlast | output | 1 | Forwarded last flag |
| bus_rvalid | input | 1 | Bus read-data beat valid |
| bus_rready | output | 1 | Gate ready for a read-data beat |
| bus_raddr | input | AW | Address the read beat belongs to |
| bus_rdata | input | DW | Read data |
| bus_rlast | input | 1 | Read last flag |
| bus_rsize | input | 2 | Read size code |
| ip_rvalid | output | 1 | Read beat delivered to IP |
| ip_rready | input | 1 | IP accepts read beat |
| ip_raddr | output | AW | Address of delivered read beat |
| ip_rdata | output | DW | Delivered read data |
| ip_rlast | output | 1 | Delivered last flag |
| chk_req | output | 1 | Beat awaiting a verdict |
| chk_write | output | 1 | Direction of presented beat (1 = write) |
| chk_addr | output | AW | Address of presented beat |
| chk_size | output | 2 | Size code of presented beat |
| chk_done | input | 1 | Checker completion strobe |
| chk_pass | input | 1 | Verdict, valid with `chk_done` |

## Verification
A lane stuck outside idle shows up on the following cycle as an upstream ready that never returns, or as `chk_req` staying high after a completion. A decision register that is set wrongly shows up as a downstream valid one cycle early or late relative to the verdict, or as a valid that appears after a fail. A synchronization bank that misses its clear shows up on the next cycle as a second handshake for the same beat, so the count of forwarded beats exceeds the number of passes. An arbiter that loses its owner shows up at once as `chk_write` or `chk_addr` changing while a verdict is still pending.

// File: rtl/xg_pkg.sv
package xg_pkg;
  localparam int SIZE_W = 2;

  typedef enum logic [1:0] {
    LN_IDLE = 2'd0,
    LN_WAIT = 2'd1,
    LN_DEC  = 2'd2,
    LN_SEND = 2'd3
  } lane_st_e;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_WR   = 2'd1,
    OWN_RD   = 2'd2
  } owner_e;
endpackage

// File: rtl/xg_decide.sv
module xg_decide (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic done,
  input  logic pass,
  output logic fire,
  output logic drop
);
  logic fire_d, fire_q;

  always_comb begin
    fire_d = active & done & pass;
    drop   = active & done & ~pass;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fire_q <= 1'b0;
    else        fire_q <= fire_d;
  end

  assign fire = fire_q;

  // R6: a rejected beat never reaches the decision register
  p_drop_no_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> !fire);
endmodule

// File: rtl/xg_sync.sv
module xg_sync #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int QW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  input  logic [QW-1:0] in_q,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [AW-1:0] out_addr,
  output logic [DW-1:0] out_data,
  output logic [QW-1:0] out_q
);
  logic vld_d, vld_q;

  always_comb begin
    vld_d = vld_q;
    if (load)                      vld_d = 1'b1;
    else if (vld_q && out_ready)   vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  // qualifier bank: loads only on the decision strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_addr <= '0;
      out_data <= '0;
      out_q    <= '0;
    end else if (load) begin
      out_addr <= in_addr;
      out_data <= in_data;
      out_q    <= in_q;
    end
  end

  assign out_valid = vld_q;

  // R3: valid can only rise after a decision strobe
  p_no_early_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !load) |=> !out_valid);
  // R4: a stalled beat holds its payload
  p_hold_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_q) && $stable(out_addr)));
  // R5: one handshake per beat
  p_single_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> !out_valid);
endmodule

// File: rtl/xg_lane.sv
module xg_lane
  import xg_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int QW = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [AW-1:0]     up_addr,
  input  logic [DW-1:0]     up_data,
  input  logic [QW-1:0]     up_q,
  input  logic [SIZE_W-1:0] up_size,
  output logic              chk_req,
  output logic [AW-1:0]     chk_addr,
  output logic [SIZE_W-1:0] chk_size,
  input  logic              chk_done,
  input  logic              chk_pass,
  output logic              down_valid,
  input  logic              down_ready,
  output logic [AW-1:0]     down_addr,
  output logic [DW-1:0]     down_data,
  output logic [QW-1:0]     down_q,
  output logic              drop
);
  lane_st_e st_q, st_d;
  logic              cap_en;
  logic              dec_fire;
  logic [AW-1:0]     h_addr;
  logic [DW-1:0]     h_data;
  logic [QW-1:0]     h_q;
  logic [SIZE_W-1:0] h_size;

  assign up_ready = (st_q == LN_IDLE);
  assign cap_en   = up_valid & up_ready;
  assign chk_req  = (st_q == LN_WAIT);
  assign chk_addr = h_addr;
  assign chk_size = h_size;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      LN_IDLE: if (up_valid) st_d = LN_WAIT;
      LN_WAIT: if (chk_done) st_d = chk_pass ? LN_DEC : LN_IDLE;
      LN_DEC:  st_d = LN_SEND;
      LN_SEND: if (down_valid && down_ready) st_d = LN_IDLE;
      default: st_d = LN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= LN_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_addr <= '0;
      h_data <= '0;
      h_q    <= '0;
      h_size <= '0;
    end else if (cap_en) begin
      h_addr <= up_addr;
      h_data <= up_data;
      h_q    <= up_q;
      h_size <= up_size;
    end
  end

  xg_decide u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (chk_req),
    .done   (chk_done),
    .pass   (chk_pass),
    .fire   (dec_fire),
    .drop   (drop)
  );

  xg_sync #(.AW(AW), .DW(DW), .QW(QW)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (dec_fire),
    .in_addr   (h_addr),
    .in_data   (h_data),
    .in_q      (h_q),
    .out_ready (down_ready),
    .out_valid (down_valid),
    .out_addr  (down_addr),
    .out_data  (down_data),
    .out_q     (down_q)
  );

  // R2: accepting a beat closes the upstream side
  p_ready_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_ready) |=> !up_ready);
  // R2: pending request is stable until completion
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_req && !chk_done) |=> (chk_req && $stable(chk_addr) && $stable(chk_size)));
  // R6: a drop reopens the upstream side at once
  p_drop_reopen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> up_ready);
endmodule

// File: rtl/xg_arb.sv
module xg_arb
  import xg_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              w_req,
  input  logic [AW-1:0]     w_addr,
  input  logic [SIZE_W-1:0] w_size,
  input  logic              r_req,
  input  logic [AW-1:0]     r_addr,
  input  logic [SIZE_W-1:0] r_size,
  input  logic              done,
  output logic              w_done,
  output logic              r_done,
  output logic              req,
  output logic              is_write,
  output logic [AW-1:0]     addr,
  output logic [SIZE_W-1:0] size
);
  owner_e own_q, own_d;
  logic   gnt_w, gnt_r;

  always_comb begin
    gnt_w = w_req & ((own_q == OWN_WR) | (own_q == OWN_NONE));
    gnt_r = r_req & ((own_q == OWN_RD) | ((own_q == OWN_NONE) & ~w_req));
    own_d = own_q;
    if (done && (gnt_w || gnt_r)) own_d = OWN_NONE;
    else if (own_q == OWN_NONE) begin
      if (gnt_w)      own_d = OWN_WR;
      else if (gnt_r) own_d = OWN_RD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) own_q <= OWN_NONE;
    else        own_q <= own_d;
  end

  assign req      = gnt_w | gnt_r;
  assign is_write = gnt_w;
  assign addr     = gnt_w ? w_addr : r_addr;
  assign size     = gnt_w ? w_size : r_size;
  assign w_done   = done & gnt_w;
  assign r_done   = done & gnt_r;

  // R8: a pending owner keeps the checker until completion
  p_keep_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && is_write && !done) |=> (req && is_write));
  p_keep_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !is_write && !done) |=> (req && !is_write));
  p_one_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({w_done, r_done}));
endmodule

// File: rtl/xfer_gate.sv
module xfer_gate
  import xg_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              viol_clr,
  output logic              viol,
  input  logic              ip_wvalid,
  output logic              ip_wready,
  input  logic [AW-1:0]     ip_waddr,
  input  logic [DW-1:0]     ip_wdata,
  input  logic [DW/8-1:0]   ip_wstrb,
  input  logic              ip_wlast,
  input  logic [SIZE_W-1:0] ip_wsize,
  output logic              bus_wvalid,
  input  logic              bus_wready,
  output logic [AW-1:0]     bus_waddr,
  output logic [DW-1:0]     bus_wdata,
  output logic [DW/8-1:0]   bus_wstrb,
  output logic              bus_wlast,
  input  logic              bus_rvalid,
  output logic              bus_rready,
  input  logic [AW-1:0]     bus_raddr,
  input  logic [DW-1:0]     bus_rdata,
  input  logic              bus_rlast,
  input  logic [SIZE_W-1:0] bus_rsize,
  output logic              ip_rvalid,
  input  logic              ip_rready,
  output logic [AW-1:0]     ip_raddr,
  output logic [DW-1:0]     ip_rdata,
  output logic              ip_rlast,
  output logic              chk_req,
  output logic              chk_write,
  output logic [AW-1:0]     chk_addr,
  output logic [SIZE_W-1:0] chk_size,
  input  logic              chk_done,
  input  logic              chk_pass
);
  localparam int SW = DW / 8;
  localparam int WQ = SW + 1;
  localparam int RQ = 1;

  logic              w_req, r_req, w_done, r_done, w_drop, r_drop;
  logic [AW-1:0]     w_caddr, r_caddr;
  logic [SIZE_W-1:0] w_csize, r_csize;
  logic [WQ-1:0]     w_dq;
  logic [RQ-1:0]     r_dq;
  logic              viol_d, viol_q;

  xg_lane #(.AW(AW), .DW(DW), .QW(WQ)) u_wlane (
    .clk        (clk),
    .rst_n      (rst_n),
    .up_valid   (ip_wvalid),
    .up_ready   (ip_wready),
    .up_addr    (ip_waddr),
    .up_data    (ip_wdata),
    .up_q       ({ip_wstrb, ip_wlast}),
    .up_size    (ip_wsize),
    .chk_req    (w_req),
    .chk_addr   (w_caddr),
    .chk_size   (w_csize),
    .chk_done   (w_done),
    .chk_pass   (chk_pass),
    .down_valid (bus_wvalid),
    .down_ready (bus_wready),
    .down_addr  (bus_waddr),
    .down_data  (bus_wdata),
    .down_q     (w_dq),
    .drop       (w_drop)
  );

  xg_lane #(.AW(AW), .DW(DW), .QW(RQ)) u_rlane (
    .clk        (clk),
    .rst_n      (rst_n),
    .up_valid   (bus_rvalid),
    .up_ready   (bus_rready),
    .up_addr    (bus_raddr),
    .up_data    (bus_rdata),
    .up_q       (bus_rlast),
    .up_size    (bus_rsize),
    .chk_req    (r_req),
    .chk_addr   (r_caddr),
    .chk_size   (r_csize),
    .chk_done   (r_done),
    .chk_pass   (chk_pass),
    .down_valid (ip_rvalid),
    .down_ready (ip_rready),
    .down_addr  (ip_raddr),
    .down_data  (ip_rdata),
    .down_q     (r_dq),
    .drop       (r_drop)
  );

  assign bus_wstrb = w_dq[WQ-1:1];
  assign bus_wlast = w_dq[0];
  assign ip_rlast  = r_dq[0];

  xg_arb #(.AW(AW)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .w_req    (w_req),
    .w_addr   (w_caddr),
    .w_size   (w_csize),
    .r_req    (r_req),
    .r_addr   (r_caddr),
    .r_size   (r_csize),
    .done     (chk_done),
    .w_done   (w_done),
    .r_done   (r_done),
    .req      (chk_req),
    .is_write (chk_write),
    .addr     (chk_addr),
    .size     (chk_size)
  );

  always_comb begin
    viol_d = viol_q;
    if (w_drop || r_drop) viol_d = 1'b1;
    else if (viol_clr)    viol_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) viol_q <= 1'b0;
    else        viol_q <= viol_d;
  end

  assign viol = viol_q;

  // R7: drops set the flag, clear works only without a drop
  p_viol_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (w_drop || r_drop) |=> viol);
  p_viol_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_clr && !w_drop && !r_drop) |=> !viol);
  // R4: forwarding follows a pass verdict by two edges
  p_wr_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wvalid) |-> $past(chk_done && chk_pass && chk_write, 2));
  p_rd_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ip_rvalid) |-> $past(chk_done && chk_pass && chk_req && !chk_write, 2));
endmodule

// File: tb/tb_xfer_gate.sv
module tb_xfer_gate;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk, rst_n, viol_clr, viol;
  logic ip_wvalid, ip_wready, ip_wlast;
  logic [AW-1:0] ip_waddr; logic [DW-1:0] ip_wdata; logic [3:0] ip_wstrb; logic [1:0] ip_wsize;
  logic bus_wvalid, bus_wready, bus_wlast;
  logic [AW-1:0] bus_waddr; logic [DW-1:0] bus_wdata; logic [3:0] bus_wstrb;
  logic bus_rvalid, bus_rready, bus_rlast;
  logic [AW-1:0] bus_raddr; logic [DW-1:0] bus_rdata; logic [1:0] bus_rsize;
  logic ip_rvalid, ip_rready, ip_rlast;
  logic [AW-1:0] ip_raddr; logic [DW-1:0] ip_rdata;
  logic chk_req, chk_write, chk_done, chk_pass;
  logic [AW-1:0] chk_addr; logic [1:0] chk_size;

  int n_checks = 0, n_err = 0;
  int fwd_w = 0, fwd_r = 0, exp_w = 0, exp_r = 0;
  bit clr_on_verdict = 0;

  xfer_gate #(.AW(AW), .DW(DW)) dut (.*);

  initial clk = 0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (rst_n && bus_wvalid && bus_wready) fwd_w++;
    if (rst_n && ip_rvalid && ip_rready)   fwd_r++;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_fwd_ok(input int got, input int want);
    return got == want;
  endfunction

  task automatic run_wr(input bit pass, input int cdly, input int rdly);
    logic [31:0] a, d; logic [3:0] s; logic l; logic [1:0] z;
    a = $urandom; d = $urandom; s = 4'($urandom); l = 1'($urandom); z = 2'($urandom);
    @(negedge clk);
    check(ip_wready == 1, "R2", "wready idle", ip_wready, 1);
    ip_wvalid = 1; ip_waddr = a; ip_wdata = d; ip_wstrb = s; ip_wlast = l; ip_wsize = z;
    @(negedge clk);
    ip_wvalid = 0;
    check(ip_wready == 0, "R2", "wready after accept", ip_wready, 0);
    check(chk_req && chk_write, "R2", "write request", {chk_req, chk_write}, 2'b11);
    check(chk_addr == a, "R2", "chk_addr", chk_addr, a);
    check(chk_size == z, "R2", "chk_size", chk_size, z);
    check(bus_wvalid == 0, "R3", "early wvalid", bus_wvalid, 0);
    for (int i = 0; i < cdly; i++) begin
      @(negedge clk);
      check(bus_wvalid == 0 && chk_req && chk_addr == a, "R3", "pending", bus_wvalid, 0);
    end
    chk_done = 1; chk_pass = pass; viol_clr = clr_on_verdict;
    @(negedge clk);
    chk_done = 0; viol_clr = 0;
    if (pass) begin
      check(bus_wvalid == 0, "R4", "wvalid one edge after", bus_wvalid, 0);
      @(negedge clk);
      check(bus_wvalid == 1, "R4", "wvalid two edges after", bus_wvalid, 1);
      check(bus_wdata == d && bus_waddr == a, "R4", "wdata", bus_wdata, d);
      check(bus_wstrb == s && bus_wlast == l, "R4", "wstrb/wlast", {bus_wstrb, bus_wlast}, {s, l});
      check(ip_wready == 0, "R2", "wready while sending", ip_wready, 0);
      for (int i = 0; i < rdly; i++) begin
        @(negedge clk);
        check(bus_wvalid == 1 && bus_wdata == d, "R4", "stall hold", bus_wdata, d);
      end
      bus_wready = 1;
      @(negedge clk);
      bus_wready = 0;
      exp_w++;
      check(bus_wvalid == 0, "R5", "wvalid after handshake", bus_wvalid, 0);
      check(ip_wready == 1, "R5", "wready after handshake", ip_wready, 1);
    end else begin
      check(ip_wready == 1, "R6", "wready after drop", ip_wready, 1);
      check(viol == 1, "R7", "viol after write drop", viol, 1);
      bus_wready = 1;
      for (int i = 0; i < 2; i++) begin
        @(negedge clk);
        check(bus_wvalid == 0, "R6", "dropped write absent", bus_wvalid, 0);
      end
      bus_wready = 0;
    end
  endtask

  task automatic run_rd(input bit pass, input int cdly, input int rdly);
    logic [31:0] a, d; logic l; logic [1:0] z;
    a = $urandom; d = $urandom; l = 1'($urandom); z = 2'($urandom);
    @(negedge clk);
    check(bus_rready == 1, "R2", "rready idle", bus_rready, 1);
    bus_rvalid = 1; bus_raddr = a; bus_rdata = d; bus_rlast = l; bus_rsize = z;
    @(negedge clk);
    bus_rvalid = 0;
    check(bus_rready == 0, "R2", "rready after accept", bus_rready, 0);
    check(chk_req && !chk_write, "R2", "read request", {chk_req, chk_write}, 2'b10);
    check(chk_addr == a && chk_size == z, "R2", "read addr/size", chk_addr, a);
    for (int i = 0; i < cdly; i++) begin
      @(negedge clk);
      check(ip_rvalid == 0, "R3", "early rvalid", ip_rvalid, 0);
    end
    chk_done = 1; chk_pass = pass; viol_clr = clr_on_verdict;
    @(negedge clk);
    chk_done = 0; viol_clr = 0;
    if (pass) begin
      check(ip_rvalid == 0, "R4", "rvalid one edge after", ip_rvalid, 0);
      @(negedge clk);
      check(ip_rvalid == 1 && ip_rdata == d, "R4", "rdata", ip_rdata, d);
      check(ip_raddr == a && ip_rlast == l, "R4", "raddr/rlast", ip_raddr, a);
      for (int i = 0; i < rdly; i++) begin
        @(negedge clk);
        check(ip_rvalid == 1 && ip_rdata == d, "R4", "read stall hold", ip_rdata, d);
      end
      ip_rready = 1;
      @(negedge clk);
      ip_rready = 0;
      exp_r++;
      check(ip_rvalid == 0 && bus_rready == 1, "R5", "read single beat", ip_rvalid, 0);
    end else begin
      check(bus_rready == 1, "R6", "rready after drop", bus_rready, 1);
      check(viol == 1, "R7", "viol after read drop", viol, 1);
      ip_rready = 1;
      for (int i = 0; i < 2; i++) begin
        @(negedge clk);
        check(ip_rvalid == 0, "R6", "dropped read returns nothing", ip_rvalid, 0);
      end
      ip_rready = 0;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_checks++; n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    logic [31:0] aw, ar, dw, dr;
    void'($urandom(32'd20240611));
    rst_n = 0; viol_clr = 0; chk_done = 0; chk_pass = 0;
    ip_wvalid = 0; ip_waddr = 0; ip_wdata = 0; ip_wstrb = 0; ip_wlast = 0; ip_wsize = 0;
    bus_wready = 0; bus_rvalid = 0; bus_raddr = 0; bus_rdata = 0; bus_rlast = 0; bus_rsize = 0;
    ip_rready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(ip_wready && bus_rready, "R1", "readies", {ip_wready, bus_rready}, 2'b11);
    check(!bus_wvalid && !ip_rvalid, "R1", "valids", {bus_wvalid, ip_rvalid}, 0);
    check(!chk_req && !viol, "R1", "req/viol", {chk_req, viol}, 0);

    // directed corners
    run_wr(1, 0, 0);
    run_rd(1, 0, 0);
    run_wr(0, 2, 0);
    // R7 clear
    @(negedge clk); viol_clr = 1;
    @(negedge clk); viol_clr = 0;
    check(viol == 0, "R7", "clear", viol, 0);
    // R7 fail wins over clear in same cycle
    clr_on_verdict = 1;
    run_rd(0, 1, 0);
    clr_on_verdict = 0;
    check(viol == 1, "R7", "set beats clear", viol, 1);
    @(negedge clk); viol_clr = 1;
    @(negedge clk); viol_clr = 0;

    // R8 both lanes at once: write served first
    aw = $urandom; ar = $urandom; dw = $urandom; dr = $urandom;
    @(negedge clk);
    ip_wvalid = 1; ip_waddr = aw; ip_wdata = dw; ip_wstrb = 4'hf; ip_wlast = 1;
    bus_rvalid = 1; bus_raddr = ar; bus_rdata = dr; bus_rlast = 0;
    @(negedge clk);
    ip_wvalid = 0; bus_rvalid = 0;
    check(chk_req && chk_write && chk_addr == aw, "R8", "write first", chk_addr, aw);
    @(negedge clk);
    check(chk_write && chk_addr == aw, "R8", "owner held", chk_addr, aw);
    chk_done = 1; chk_pass = 1;
    @(negedge clk);
    chk_done = 0;
    check(chk_req && !chk_write && chk_addr == ar, "R8", "read next", chk_addr, ar);
    chk_done = 1; chk_pass = 1;
    @(negedge clk);
    chk_done = 0;
    check(bus_wvalid && !ip_rvalid, "R8", "write out first", {bus_wvalid, ip_rvalid}, 2'b10);
    @(negedge clk);
    check(ip_rvalid && ip_rdata == dr && bus_wdata == dw, "R8", "both out", ip_rdata, dr);
    bus_wready = 1; ip_rready = 1;
    @(negedge clk);
    bus_wready = 0; ip_rready = 0;
    exp_w++; exp_r++;
    check(!bus_wvalid && !ip_rvalid, "R5", "both single", {bus_wvalid, ip_rvalid}, 0);

    // constrained random
    for (int k = 0; k < 60; k++) begin
      bit p; int cd, rd;
      p = ($urandom % 3) != 0; cd = int'($urandom % 4); rd = int'($urandom % 3);
      if ($urandom % 2) run_wr(p, cd, rd);
      else              run_rd(p, cd, rd);
    end

    @(negedge clk);
    check(exp_fwd_ok(fwd_w, exp_w), "R5", "write beats forwarded", 64'(fwd_w), 64'(exp_w));
    check(exp_fwd_ok(fwd_r, exp_r), "R5", "read beats forwarded", 64'(fwd_r), 64'(exp_r));
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule